// File: doc/BRIEF.md
# Character-ROM Bank and Mirroring Mapper

This block sits on the video side of a cartridge memory controller. It turns video-bus reads that fall in the pattern-table area (addresses below 0x2000) into byte addresses for a character ROM. Eight 16-bit bank registers hold the bank numbers. A 2-bit granularity mode from a shared control register picks how the 8 KB pattern area is cut into slots and which registers feed those slots.

The CPU loads each bank register one byte at a time, through two separate write offsets per register. A further write offset sets a 2-bit mirroring selector. That selector drives the page-select line of the nametable RAM for video accesses at and above 0x2000. All outputs are registered, so a read result appears one clock after the video address is presented.

Top module: `chr_bank_mapper`

## Requirements
- R1: After a synchronous active-high reset, every bank register is 0, mirroring is vertical (code 0), and the registered outputs are 0.
- R2: A write at offset 0x1000+n (n in 0..7) replaces bits [7:0] of bank register n and leaves bits [15:8] unchanged.
- R3: A write at offset 0x2000+n (n in 0..7) replaces bits [15:8] of bank register n and leaves bits [7:0] unchanged.
- R4: Mode 0 maps the whole 8 KB area as one slot from register 0: address = bank0 * 0x2000 + (vaddr mod 0x2000).
- R5: Mode 1 uses two 4 KB slots. Register 0 serves vaddr below 0x1000 and register 4 serves 0x1000 to 0x1FFF.
- R6: Mode 2 uses four 2 KB slots, fed in address order by registers 0, 2, 4 and 6.
- R7: Mode 3 uses eight 1 KB slots, fed in address order by registers 0 to 7.
- R8: Before use, each bank number is ANDed with (ROM size / slot size) - 1.
- R9: pat_hit is 1 exactly when vaddr < 0x2000. When vaddr >= 0x2000, chr_addr is 0.
- R10: A write at offset 0x5001 loads the mirroring code from data bits [1:0]. Code 0 (vertical) gives nt_page = vaddr[10], code 1 (horizontal) gives vaddr[11], code 2 forces 0 and code 3 forces 1.
- R11: chr_addr, pat_hit and nt_page are registered. They reflect the inputs and register state sampled at the previous rising clock edge.
- R12: Writes to any other offset, and cycles with wr_en low, change no bank register and no mirroring code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_ofs | input | 15 | Write offset within the mapper window |
| wr_data | input | 8 | CPU write data |
| chr_mode | input | 2 | Character granularity mode from the shared control register |
| vaddr | input | 14 | Video bus address |
| chr_addr | output | CHR_AW | Registered character-ROM byte address |
| pat_hit | output | 1 | Registered flag: the access is a pattern-table read |
| nt_page | output | 1 | Registered nametable RAM page-select line |

## Verification
The assertions assume that reset is held for at least one clock edge before use, and that the CPU port issues at most one write per cycle with the offset and data stable around the edge. They also assume the ROM size is a power of two of at least 8 KB, so that each slot mask is a contiguous group of low bits. The bench drives every input on the falling edge and leaves a full clock between a register write and the probe that depends on it. It checks outputs only on the falling edge after the one rising edge that registers them, and it keeps the 1024 KB build in which bits of the high byte become visible through the masks.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  localparam int OFS_W      = 15;
  localparam int VA_W       = 14;
  localparam int PAT_SPAN   = 'h2000;
  localparam logic [OFS_W-1:0] OFS_BYTE_STEP = 15'h1000;
  localparam logic [OFS_W-1:0] OFS_MIRROR    = 15'h5001;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter int NREG = 8,
  parameter int BW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     wr_ofs,
  input  logic [7:0]           wr_data,
  output logic [NREG*BW-1:0]   bank_flat,
  output mirror_e              mir
);
  localparam int NBYTE = BW / 8;

  mirror_e mir_q;

  for (genvar n = 0; n < NREG; n++) begin : g_reg
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      localparam logic [OFS_W-1:0] MY_OFS = OFS_W'((b + 1) * 'h1000 + n);
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst) byte_q <= '0;
        else if (wr_en && wr_ofs == MY_OFS) byte_q <= wr_data;
      end
      assign bank_flat[n*BW + b*8 +: 8] = byte_q;
    end

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_ofs == OFS_W'('h1000 + n)) |=>
        (bank_flat[n*BW +: 8] == $past(wr_data) &&
         bank_flat[n*BW+8 +: 8] == $past(bank_flat[n*BW+8 +: 8])));
    // R3
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_ofs == OFS_W'('h2000 + n)) |=>
        (bank_flat[n*BW+8 +: 8] == $past(wr_data) &&
         bank_flat[n*BW +: 8] == $past(bank_flat[n*BW +: 8])));
  end

  always_ff @(posedge clk) begin
    if (rst) mir_q <= MIR_VERT;
    else if (wr_en && wr_ofs == OFS_MIRROR) mir_q <= mirror_e'(wr_data[1:0]);
  end
  assign mir = mir_q;

  // R10
  mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ofs == OFS_MIRROR) |=> (mir == mirror_e'($past(wr_data[1:0]))));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (bank_flat == $past(bank_flat) && mir == $past(mir)));
endmodule

// File: rtl/chr_bank_slot.sv
module chr_bank_slot
  import chr_bank_pkg::*;
#(
  parameter int NREG = 8,
  parameter int BW   = 16
) (
  input  logic [1:0]           mode,
  input  logic [2:0]           va_hi,
  input  logic [NREG*BW-1:0]   bank_flat,
  output logic [BW-1:0]        bank
);
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] idx;

  always_comb begin
    unique case (mode)
      2'd0:    idx = '0;
      2'd1:    idx = IW'({va_hi[2], 2'b00});
      2'd2:    idx = IW'({va_hi[2:1], 1'b0});
      default: idx = IW'(va_hi);
    endcase
  end

  assign bank = bank_flat[idx*BW +: BW];

  // R6
  always_comb begin
    if (mode == 2'd2) slot_even_chk: assert (idx[0] == 1'b0);
  end
endmodule

// File: rtl/chr_bank_addr.sv
module chr_bank_addr
  import chr_bank_pkg::*;
#(
  parameter int CHR_KB = 256,
  parameter int CHR_AW = 18,
  parameter int BW     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [BW-1:0]      bank,
  input  mirror_e            mir,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic               pat_hit,
  output logic               nt_page
);
  localparam int FW = 32;

  logic [BW-1:0]     mask;
  logic [4:0]        shamt;
  logic [FW-1:0]     offs;
  logic [FW-1:0]     full;
  logic              is_pat;
  logic              page_d;
  logic [CHR_AW-1:0] addr_q;
  logic              pat_q;
  logic              page_q;

  always_comb begin
    unique case (mode)
      2'd0:    mask = BW'(CHR_KB / 8 - 1);
      2'd1:    mask = BW'(CHR_KB / 4 - 1);
      2'd2:    mask = BW'(CHR_KB / 2 - 1);
      default: mask = BW'(CHR_KB - 1);
    endcase
    shamt = 5'(13 - int'(mode));
    offs  = FW'(vaddr[12:0]) & ((FW'(1) << shamt) - FW'(1));
    full  = ({{(FW-BW){1'b0}}, bank & mask} << shamt) | offs;
    is_pat = (int'(vaddr) < PAT_SPAN);
  end

  always_comb begin
    unique case (mir)
      MIR_VERT:  page_d = vaddr[10];
      MIR_HORZ:  page_d = vaddr[11];
      MIR_ONE_A: page_d = 1'b0;
      default:   page_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      pat_q  <= 1'b0;
      page_q <= 1'b0;
    end else begin
      addr_q <= is_pat ? full[CHR_AW-1:0] : '0;
      pat_q  <= is_pat;
      page_q <= page_d;
    end
  end

  assign chr_addr = addr_q;
  assign pat_hit  = pat_q;
  assign nt_page  = page_q;

  // R9
  no_xlate_chk: assert property (@(posedge clk) disable iff (rst)
    (vaddr[13]) |=> (!pat_hit && chr_addr == '0));
  // R10
  one_a_chk: assert property (@(posedge clk) disable iff (rst)
    (mir == MIR_ONE_A) |=> !nt_page);
  // R10
  one_b_chk: assert property (@(posedge clk) disable iff (rst)
    (mir == MIR_ONE_B) |=> nt_page);
  // R11
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!vaddr[13] && mode == 2'd3) |=> (chr_addr[9:0] == $past(vaddr[9:0])));
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_bank_pkg::*;
#(
  parameter int CHR_KB = 256,
  parameter int CHR_AW = $clog2(CHR_KB) + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [14:0]       wr_ofs,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        chr_mode,
  input  logic [13:0]       vaddr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              pat_hit,
  output logic              nt_page
);
  localparam int NREG = 8;
  localparam int BW   = 16;

  logic [NREG*BW-1:0] bank_flat;
  logic [BW-1:0]      bank;
  mirror_e            mir;

  chr_bank_regs #(.NREG(NREG), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .bank_flat(bank_flat), .mir(mir)
  );

  chr_bank_slot #(.NREG(NREG), .BW(BW)) u_slot (
    .mode(chr_mode), .va_hi(vaddr[12:10]), .bank_flat(bank_flat), .bank(bank)
  );

  chr_bank_addr #(.CHR_KB(CHR_KB), .CHR_AW(CHR_AW), .BW(BW)) u_addr (
    .clk(clk), .rst(rst), .mode(chr_mode), .vaddr(vaddr), .bank(bank),
    .mir(mir), .chr_addr(chr_addr), .pat_hit(pat_hit), .nt_page(nt_page)
  );
endmodule

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;
  localparam int KB = 1024;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [14:0]   wr_ofs = '0;
  logic [7:0]    wr_data = '0;
  logic [1:0]    chr_mode = '0;
  logic [13:0]   vaddr = '0;
  logic [AW-1:0] chr_addr;
  logic          pat_hit;
  logic          nt_page;

  int checks = 0;
  int errors = 0;
  int m_bank [8];
  int m_mir = 0;

  always #10 clk = ~clk;

  chr_bank_mapper #(.CHR_KB(KB), .CHR_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .chr_mode(chr_mode), .vaddr(vaddr), .chr_addr(chr_addr),
    .pat_hit(pat_hit), .nt_page(nt_page)
  );

  function automatic int exp_addr(int mode, int va);
    int slot, which, bnk;
    if (va >= 'h2000) return 0;
    slot = 'h2000 >> mode;
    which = (va / slot) * (8 >> mode);
    bnk = m_bank[which] % (KB * 1024 / slot);
    return bnk * slot + va % slot;
  endfunction

  function automatic int exp_page(int va);
    case (m_mir)
      0: return (va >> 10) & 1;
      1: return (va >> 11) & 1;
      2: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(int ofs, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = 15'(ofs); wr_data = 8'(data);
    if (ofs >= 'h1000 && ofs <= 'h1007)
      m_bank[ofs-'h1000] = (m_bank[ofs-'h1000] & 'hFF00) | (data & 'hFF);
    if (ofs >= 'h2000 && ofs <= 'h2007)
      m_bank[ofs-'h2000] = (m_bank[ofs-'h2000] & 'h00FF) | ((data & 'hFF) << 8);
    if (ofs == 'h5001) m_mir = data & 3;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_bank(int n, int v);
    cpu_wr('h1000 + n, v & 'hFF);
    cpu_wr('h2000 + n, (v >> 8) & 'hFF);
  endtask

  task automatic probe(string req, int mode, int va);
    chr_mode = 2'(mode); vaddr = 14'(va);
    @(negedge clk);
    check(req, int'(chr_addr), exp_addr(mode, va));
    check(req, int'(pat_hit), (va < 'h2000) ? 1 : 0);
    if (va >= 'h2000) check(req, int'(nt_page), exp_page(va));
  endtask

  task automatic t_reset();
    check("R1", int'(chr_addr), 0);
    check("R1", int'(pat_hit), 0);
    check("R1", int'(nt_page), 0);
    probe("R1", 3, 'h1C05);
    probe("R1", 0, 'h2400);
  endtask

  task automatic t_bytes();
    set_bank(1, 'h00FF);
    cpu_wr('h1001, 'h12);
    probe("R2", 3, 'h0405);
    cpu_wr('h2001, 'h01);
    probe("R3", 3, 'h0406);
    cpu_wr('h2001, 'h03);
    probe("R3", 3, 'h07FF);
  endtask

  task automatic t_modes();
    for (int n = 0; n < 8; n++) set_bank(n, 'h0135 + n * 'h0102);
    probe("R4", 0, 'h0000);
    probe("R4", 0, 'h1ABC);
    probe("R5", 1, 'h0FFF);
    probe("R5", 1, 'h1001);
    probe("R6", 2, 'h0123);
    probe("R6", 2, 'h0900);
    probe("R6", 2, 'h1234);
    probe("R6", 2, 'h1FFE);
    for (int s = 0; s < 8; s++) probe("R7", 3, s * 'h400 + 'h3 * s);
  endtask

  task automatic t_mask();
    set_bank(0, 'hFFFF);
    probe("R8", 0, 'h0010);
    probe("R8", 1, 'h0020);
    probe("R8", 2, 'h0030);
    probe("R8", 3, 'h0040);
  endtask

  task automatic t_mirror();
    for (int c = 0; c < 4; c++) begin
      cpu_wr('h5001, 'hFC | c);
      probe("R10", 0, 'h2400);
      probe("R10", 0, 'h2800);
      probe("R9", 1, 'h3C00);
    end
  endtask

  task automatic t_latency();
    probe("R11", 3, 'h0000);
    chr_mode = 2'd3; vaddr = 14'h1C00;
    #2;
    check("R11", int'(chr_addr), exp_addr(3, 'h0000));
    @(negedge clk);
    check("R11", int'(chr_addr), exp_addr(3, 'h1C00));
  endtask

  task automatic t_ignored();
    cpu_wr('h5001, 2);
    cpu_wr('h1008, 'hAA);
    cpu_wr('h2008, 'hAA);
    cpu_wr('h5000, 'hFF);
    cpu_wr('h5002, 'h01);
    cpu_wr('h0001, 'h77);
    @(negedge clk);
    wr_ofs = 15'h1003; wr_data = 8'h55;
    @(negedge clk);
    for (int s = 0; s < 8; s++) probe("R12", 3, s * 'h400 + 1);
    probe("R12", 0, 'h2C00);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) m_bank[n] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_modes();
    t_mask();
    t_mirror();
    t_latency();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule